// File: doc/BRIEF.md
# Hold-Register SPI Master

This block is a character-oriented serial master placed between a processor register port and a four-wire serial link. The processor writes one character at a time into a transmit holding register and reads each reply from a receive holding register. Two event flags report the state of these registers: "transmit not full" and "receive not empty". The processor packs and unpacks its data into characters whose length it selects in the control register.

A frame opens on the first transmit write after an idle period and is marked by the slave-select output going low. Characters are exchanged full duplex, most significant bit first. The serial clock idles low, outgoing data changes on its falling edge and incoming data is sampled on its rising edge. To close the frame, software sets the last-character command bit and then writes the final character. After that character the select output rises, the serial clock stops and the command bit clears itself.

If another master drives the select input active while this block is enabled, the block records a multi-master error. It leaves master mode and releases its clock and data outputs. Each event bit can raise the interrupt line through its own enable.

Top module: `spim_master`

## Requirements
- R1: After reset, irq is 0, ss_n_o is 1, sck_o is 0, sck_oe and mosi_oe are 0, and the event register (address 2) reads 0x1 (bit0 = transmit-not-full set, all other bits clear).
- R2: A write to the transmit register (address 3) clears the not-full bit (event bit0). The character stays held while master mode (control bit0) is off. The bit sets again once the shifter takes the character.
- R3: The not-empty bit (event bit1) sets when a received character is placed in the receive register (address 4). A read of address 4 with bus_rd high clears it.
- R4: Control bits [11:8] hold the character length minus one. Only that many low bits of the transmit word are sent. Receive-register bits above the length read 0.
- R5: Each character is exchanged full duplex and MSB first. mosi_o changes only while sck_o falls and miso_i is sampled as sck_o rises. sck_o idles low.
- R6: ss_n_o goes low when the first character of a frame is loaded. It stays low between consecutive characters and rises only after the character that was loaded with the last-character bit set.
- R7: When a frame ends, the last-character command bit (address 1, bit0) clears by itself. sck_o then stays low and ss_n_o stays high until the next transmit write.
- R8: A character that completes while the receive register is still full sets the overrun bit (event bit2) and is discarded. The overrun bit clears when a 1 is written to event bit2.
- R9: irq is high exactly while some event bit is set whose enable is set. The enables are control bits [27:24], in event-bit order: not-full, not-empty, overrun, multi-master.
- R10: When ssel_n_i is held low while master mode is on, event bit3 sets, control bit0 clears, sck_oe and mosi_oe drop to 0, and ss_n_o returns high. Event bit3 clears when a 1 is written to it.
- R11: sck_o stays high, and stays low within a character, for divider+1 system clocks, where the divider is control bits [23:16].
- R12: A write to the transmit register while it is still full is ignored; the held character is not replaced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle |
| bus_wr | input | 1 | Write qualifier for bus_sel |
| bus_rd | input | 1 | Read qualifier; pops the receive register at address 4 |
| bus_addr | input | 3 | Register address: 0 control, 1 command, 2 event, 3 transmit, 4 receive |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data output enable |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | 1 | Active-low slave select for the frame |
| ssel_n_i | input | 1 | Active-low select input watched for a conflicting master |

## Verification
The embedded properties assume the following of the inputs. Every bus strobe lasts one cycle. Software changes neither the length nor the divider while a character is in flight. The last-character bit is written only once the transmit register has been emptied. The bench keeps to this. It reprograms the control register only while the link is idle, and it polls the not-full flag before it sets the last-character bit in a multi-character frame. It drives ssel_n_i low only in the conflict scenario, where it holds it long enough for the two-stage synchronizer to see it.

// File: rtl/spim_pkg.sv
// Package: shared register addresses and field positions for the SPI master.
// Assumes a 32-bit register bus; character width is set at the top level.
package spim_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_CMD  = 3'd1,
        REG_EVT  = 3'd2,
        REG_TXD  = 3'd3,
        REG_RXD  = 3'd4
    } spim_addr_e;

    // control register field positions
    localparam int CTL_EN  = 0;
    localparam int CTL_LEN = 8;
    localparam int CTL_DIV = 16;
    localparam int CTL_IE  = 24;

    // event register bit positions (also interrupt enable order)
    localparam int EV_NF  = 0;
    localparam int EV_NE  = 1;
    localparam int EV_OVR = 2;
    localparam int EV_MME = 3;
    localparam int EV_N   = 4;

    // command register
    localparam int CMD_LAST = 0;

endpackage

// File: rtl/spim_baud.sv
// Module: serial clock tick generator.
// Produces one tick every DIV+1 system clocks while run is high; the count
// restarts whenever run is low so the first half period is always full length.
module spim_baud #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);

    logic [DIVW-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    // counts system clocks between ticks
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // a nonzero divider never yields two ticks in a row
    p_tick_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && $stable(div)) |=> !tick);

endmodule

// File: rtl/spim_mmdet.sv
// Module: conflicting-master detector.
// Synchronizes the active-low select input and flags a hit while armed.
// Assumes the input is asynchronous; two flops give a two-cycle latency.
module spim_mmdet (
    input  logic clk,
    input  logic rst_n,
    input  logic ssel_n_i,
    input  logic armed,
    output logic hit
);

    logic s1_q, s2_q;

    // two-stage synchronizer, idles inactive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= ssel_n_i;
            s2_q <= s1_q;
        end
    end

    assign hit = armed && !s2_q;

endmodule

// File: rtl/spim_shift.sv
// Module: character shifter and frame sequencer.
// Loads a character from the transmit holder, exchanges it MSB first with
// sck idle low (out on falling, in on rising), and keeps the frame open until
// a character loaded with the last flag completes. Disabling aborts at once.
module spim_shift #(
    parameter int DW = 16,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic [LW-1:0] len_m1,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_last,
    input  logic          miso,
    output logic          tx_take,
    output logic          rx_push,
    output logic [DW-1:0] rx_data,
    output logic          last_done,
    output logic          busy,
    output logic          sck,
    output logic          mosi,
    output logic          ss_n
);

    localparam logic [LW:0] ONE = (LW+1)'(1);

    logic          busy_q, frame_q, sck_q, last_q;
    logic [LW:0]   bit_q;
    logic [DW-1:0] tx_q, rx_q;
    logic [LW:0]   nbits;
    logic [LW-1:0] lpad;
    logic          char_end;

    assign nbits    = {1'b0, len_m1} + ONE;
    assign lpad     = LW'(DW-1) - len_m1;
    assign tx_take  = en && !busy_q && tx_valid;
    assign char_end = busy_q && tick && sck_q && (bit_q == nbits);

    assign rx_push   = char_end;
    assign rx_data   = rx_q;
    assign last_done = char_end && last_q;
    assign busy      = busy_q;
    assign sck       = sck_q;
    assign mosi      = tx_q[DW-1];
    assign ss_n      = !frame_q;

    // sequences load, rising/falling half periods and frame close
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            frame_q <= 1'b0;
            sck_q   <= 1'b0;
            last_q  <= 1'b0;
            bit_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
        end else if (!en) begin
            busy_q  <= 1'b0;
            frame_q <= 1'b0;
            sck_q   <= 1'b0;
        end else if (tx_take) begin
            busy_q  <= 1'b1;
            frame_q <= 1'b1;
            sck_q   <= 1'b0;
            bit_q   <= '0;
            tx_q    <= tx_data << lpad;
            rx_q    <= '0;
            last_q  <= tx_last;
        end else if (busy_q && tick) begin
            if (!sck_q) begin
                sck_q <= 1'b1;
                rx_q  <= {rx_q[DW-2:0], miso};
                bit_q <= bit_q + ONE;
            end else begin
                sck_q <= 1'b0;
                if (bit_q == nbits) begin
                    busy_q <= 1'b0;
                    if (last_q)
                        frame_q <= 1'b0;
                end else begin
                    tx_q <= {tx_q[DW-2:0], 1'b0};
                end
            end
        end
    end

    // no clock outside a frame
    p_sck_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_q |-> !sck_q);

    // outgoing data is steady across each rising edge
    p_mosi_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $rose(sck_q)) |-> $stable(tx_q[DW-1]));

    // frame closes after the marked character
    p_frame_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_done && en) |=> ss_n);

    // an unmarked character keeps the frame open
    p_frame_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (char_end && !last_q && en) |=> !ss_n);

endmodule

// File: rtl/spim_regs.sv
// Module: register file, hold registers and event flags.
// Single-entry transmit and receive holders; not-full/not-empty follow
// occupancy, overrun and multi-master bits are sticky write-one-to-clear.
// Assumes one-cycle bus strobes.
module spim_regs
    import spim_pkg::*;
#(
    parameter int DW   = 16,
    parameter int LW   = 4,
    parameter int DIVW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             tx_take,
    input  logic             rx_push,
    input  logic [DW-1:0]    rx_data,
    input  logic             last_done,
    input  logic             mm_hit,
    output logic             master_en,
    output logic [LW-1:0]    len_m1,
    output logic [DIVW-1:0]  div,
    output logic             tx_valid,
    output logic [DW-1:0]    tx_data,
    output logic             tx_last,
    output logic             irq
);

    logic            en_q;
    logic [LW-1:0]   len_q;
    logic [DIVW-1:0] div_q;
    logic [EV_N-1:0] ie_q;
    logic            last_q;
    logic            tx_full, rx_full, ovr_q, mme_q;
    logic [DW-1:0]   tx_hold, rx_hold;
    logic [EV_N-1:0] evt;
    logic            wr_ctrl, wr_cmd, wr_evt, wr_txd, rd_rx;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == REG_CTRL);
    assign wr_cmd  = bus_sel && bus_wr && (bus_addr == REG_CMD);
    assign wr_evt  = bus_sel && bus_wr && (bus_addr == REG_EVT);
    assign wr_txd  = bus_sel && bus_wr && (bus_addr == REG_TXD);
    assign rd_rx   = bus_sel && bus_rd && (bus_addr == REG_RXD);

    // control register; a conflicting master forces master mode off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            len_q <= '0;
            div_q <= '0;
            ie_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q  <= bus_wdata[CTL_EN];
                len_q <= bus_wdata[CTL_LEN +: LW];
                div_q <= bus_wdata[CTL_DIV +: DIVW];
                ie_q  <= bus_wdata[CTL_IE +: EV_N];
            end
            if (mm_hit)
                en_q <= 1'b0;
        end
    end

    // last-character command bit, cleared when its frame ends
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= 1'b0;
        else if (wr_cmd)
            last_q <= bus_wdata[CMD_LAST];
        else if (last_done)
            last_q <= 1'b0;
    end

    // transmit holder: accepts a write only when empty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_full <= 1'b0;
            tx_hold <= '0;
        end else if (wr_txd && !tx_full) begin
            tx_full <= 1'b1;
            tx_hold <= bus_wdata[DW-1:0];
        end else if (tx_take) begin
            tx_full <= 1'b0;
        end
    end

    // receive holder: a push into an occupied holder is dropped as overrun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
            rx_hold <= '0;
        end else if (rx_push && !(rx_full && !rd_rx)) begin
            rx_full <= 1'b1;
            rx_hold <= rx_data;
        end else if (rd_rx) begin
            rx_full <= 1'b0;
        end
    end

    // sticky error bits, set wins over write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            mme_q <= 1'b0;
        end else begin
            if (rx_push && rx_full && !rd_rx)
                ovr_q <= 1'b1;
            else if (wr_evt && bus_wdata[EV_OVR])
                ovr_q <= 1'b0;
            if (mm_hit)
                mme_q <= 1'b1;
            else if (wr_evt && bus_wdata[EV_MME])
                mme_q <= 1'b0;
        end
    end

    always_comb begin
        evt         = '0;
        evt[EV_NF]  = !tx_full;
        evt[EV_NE]  = rx_full;
        evt[EV_OVR] = ovr_q;
        evt[EV_MME] = mme_q;
    end

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL: begin
                bus_rdata[CTL_EN]             = en_q;
                bus_rdata[CTL_LEN +: LW]      = len_q;
                bus_rdata[CTL_DIV +: DIVW]    = div_q;
                bus_rdata[CTL_IE +: EV_N]     = ie_q;
            end
            REG_CMD: bus_rdata[CMD_LAST]      = last_q;
            REG_EVT: bus_rdata[EV_N-1:0]      = evt;
            REG_RXD: bus_rdata[DW-1:0]        = rx_hold;
            default: bus_rdata                = '0;
        endcase
    end

    assign master_en = en_q;
    assign len_m1    = len_q;
    assign div       = div_q;
    assign tx_valid  = tx_full;
    assign tx_data   = tx_hold;
    assign tx_last   = last_q;
    assign irq       = |(evt & ie_q);

    // a write into an empty holder makes it full
    p_tx_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txd && !tx_full) |=> tx_full);

    // a write into a full holder keeps the held character
    p_tx_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txd && tx_full && !tx_take) |=> $stable(tx_hold));

    // reading the receive holder empties it unless a new character lands
    p_ne_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !rx_push) |=> !rx_full);

    // push into an unread holder records overrun and keeps the old data
    p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rd_rx) |=> (ovr_q && $stable(rx_hold)));

    // a conflict drops master mode and records the error
    p_mm_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mm_hit |=> (!en_q && mme_q));

    // the command bit clears when its frame ends
    p_last_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (last_done && !wr_cmd) |=> !last_q);

endmodule

// File: rtl/spim_master.sv
// Module: top of the hold-register SPI master.
// Connects register file, tick generator, shifter and conflict detector.
// The serial clock and data outputs are enabled only in master mode.
module spim_master
    import spim_pkg::*;
#(
    parameter int DW   = 16,
    parameter int DIVW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq,
    output logic             sck_o,
    output logic             sck_oe,
    output logic             mosi_o,
    output logic             mosi_oe,
    input  logic             miso_i,
    output logic             ss_n_o,
    input  logic             ssel_n_i
);

    localparam int LW = $clog2(DW);

    logic            master_en, tx_valid, tx_last, tx_take;
    logic            rx_push, last_done, busy, tick, mm_hit;
    logic [LW-1:0]   len_m1;
    logic [DIVW-1:0] div;
    logic [DW-1:0]   tx_data, rx_data;

    spim_regs #(.DW(DW), .LW(LW), .DIVW(DIVW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tx_take   (tx_take),
        .rx_push   (rx_push),
        .rx_data   (rx_data),
        .last_done (last_done),
        .mm_hit    (mm_hit),
        .master_en (master_en),
        .len_m1    (len_m1),
        .div       (div),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .irq       (irq)
    );

    spim_baud #(.DIVW(DIVW)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (div),
        .tick  (tick)
    );

    spim_shift #(.DW(DW), .LW(LW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (master_en),
        .tick      (tick),
        .len_m1    (len_m1),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .miso      (miso_i),
        .tx_take   (tx_take),
        .rx_push   (rx_push),
        .rx_data   (rx_data),
        .last_done (last_done),
        .busy      (busy),
        .sck       (sck_o),
        .mosi      (mosi_o),
        .ss_n      (ss_n_o)
    );

    spim_mmdet u_mmdet (
        .clk      (clk),
        .rst_n    (rst_n),
        .ssel_n_i (ssel_n_i),
        .armed    (master_en),
        .hit      (mm_hit)
    );

    assign sck_oe  = master_en;
    assign mosi_oe = master_en;

    // outputs are released one cycle after a conflict is seen
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mm_hit |=> (!sck_oe && !mosi_oe));

endmodule

// File: tb/sim_spim_master.sv
`timescale 1ns/1ps
// Bench: behavioural slave model with queues plus per-clock protocol compare.
module sim_spim_master;

    localparam logic [2:0] A_CTRL = 3'd0, A_CMD = 3'd1, A_EVT = 3'd2,
                           A_TXD = 3'd3, A_RXD = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, sck_o, sck_oe, mosi_o, mosi_oe, ss_n_o;
    logic        miso_i = 1'b0;
    logic        ssel_n_i = 1'b1;

    always #2.5 clk = ~clk;

    spim_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i),
        .ss_n_o(ss_n_o), .ssel_n_i(ssel_n_i)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // ---------------- slave model ----------------
    int          slen = 8;
    logic [31:0] rep [32];
    int          ngot = 0;
    int          bcnt = 0;
    logic [31:0] acc = '0;
    logic [31:0] got [$];
    int          ss_rises = 0;

    always @(posedge sck_o) begin
        acc = {acc[30:0], mosi_o};
        bcnt++;
        if (bcnt == slen) begin
            got.push_back(acc);
            acc = '0;
            bcnt = 0;
            ngot++;
        end
    end

    always @(negedge sck_o or negedge ss_n_o)
        miso_i = rep[ngot % 32][slen - 1 - bcnt];

    always @(posedge ss_n_o) ss_rises++;

    // R7 every clock: no serial clock outside a frame
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (ss_n_o === 1'b1 && sck_o !== 1'b0) begin
                n_bad++;
                $display("FAIL R7 sck outside frame actual=%b expected=0", sck_o);
            end
        end
    end

    task automatic slave_reset(input int len);
        slen = len; ngot = 0; bcnt = 0; acc = '0; got.delete(); ss_rises = 0;
    endtask

    // ---------------- bus helpers ----------------
    task automatic bw(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic br(input logic [2:0] a, input bit pop, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = pop; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] cw(bit en, int len, int dv, logic [3:0] ie);
        logic [31:0] r;
        r = '0;
        r[0] = en;
        r[11:8] = 4'(len - 1);
        r[23:16] = 8'(dv);
        r[27:24] = ie;
        return r;
    endfunction

    task automatic poll_evt(input int b);
        logic [31:0] d;
        for (int i = 0; i < 4000; i++) begin
            br(A_EVT, 1'b0, d);
            if (d[b]) return;
        end
    endtask

    task automatic wait_frame(input int n);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (got.size() >= n && ss_n_o === 1'b1) break;
        end
        repeat (2) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [31:0] d;
        int n;
        for (int i = 0; i < 32; i++) rep[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 ss_n_o", ss_n_o, 1);
        chk("R1 sck_o", sck_o, 0);
        chk("R1 oe", {sck_oe, mosi_oe}, 0);
        br(A_EVT, 1'b0, d);
        chk("R1 event", d, 32'h1);

        // R2 / R12: write while master off is held; second write ignored
        slave_reset(8);
        rep[0] = 32'h3C;
        bw(A_TXD, 32'hA5);
        br(A_EVT, 1'b0, d);
        chk("R2 NF clear on write", d[0], 0);
        bw(A_TXD, 32'h5B);
        bw(A_CMD, 32'h1);
        bw(A_CTRL, cw(1, 8, 1, 4'h0));
        wait_frame(1);
        chk("R12 held char sent", got.size() > 0 ? got[0] : 32'hDEAD, 32'hA5);
        chk("R5 chars exchanged", got.size(), 1);
        br(A_EVT, 1'b0, d);
        chk("R2 NF set after take", d[0], 1);
        chk("R3 NE set", d[1], 1);
        br(A_RXD, 1'b1, d);
        chk("R5 received reply", d, 32'h3C);
        br(A_EVT, 1'b0, d);
        chk("R3 NE cleared by read", d[1], 0);
        br(A_CMD, 1'b0, d);
        chk("R7 last bit auto clear", d[0], 0);
        chk("R7 ss high after frame", ss_n_o, 1);

        // R4 five-bit characters, upper transmit bits ignored
        bw(A_CTRL, cw(1, 5, 0, 4'h0));
        slave_reset(5);
        rep[0] = 32'h13;
        bw(A_CMD, 32'h1);
        bw(A_TXD, 32'hFFE6);
        wait_frame(1);
        chk("R4 only low bits sent", got.size() > 0 ? got[0] : 32'hDEAD, 32'h06);
        br(A_RXD, 1'b1, d);
        chk("R4 rx upper bits zero", d, 32'h13);

        // R6 three-character frame
        bw(A_CTRL, cw(1, 8, 1, 4'h0));
        slave_reset(8);
        rep[0] = 32'h11; rep[1] = 32'h22; rep[2] = 32'h33;
        bw(A_CMD, 32'h0);
        bw(A_TXD, 32'hC0);
        poll_evt(0);
        bw(A_TXD, 32'hC1);
        poll_evt(1);
        br(A_RXD, 1'b1, d);
        chk("R6 first reply", d, 32'h11);
        poll_evt(0);
        bw(A_CMD, 32'h1);
        bw(A_TXD, 32'hC2);
        poll_evt(1);
        br(A_RXD, 1'b1, d);
        chk("R6 second reply", d, 32'h22);
        poll_evt(1);
        br(A_RXD, 1'b1, d);
        chk("R6 third reply", d, 32'h33);
        wait_frame(3);
        chk("R6 single select release", ss_rises, 1);
        chk("R6 chars in order", got.size() == 3 ? {got[0][7:0], got[1][7:0], got[2][7:0]} : 32'hDEAD,
            32'hC0C1C2);
        br(A_CMD, 1'b0, d);
        chk("R7 last cleared after frame", d[0], 0);

        // R8 overrun
        slave_reset(8);
        rep[0] = 32'h5A; rep[1] = 32'h77;
        bw(A_CMD, 32'h1);
        bw(A_TXD, 32'h01);
        wait_frame(1);
        bw(A_CMD, 32'h1);
        bw(A_TXD, 32'h02);
        wait_frame(2);
        br(A_EVT, 1'b0, d);
        chk("R8 overrun set", d[2], 1);
        br(A_RXD, 1'b1, d);
        chk("R8 first char kept", d, 32'h5A);
        bw(A_EVT, 32'h4);
        br(A_EVT, 1'b0, d);
        chk("R8 overrun w1c", d[2], 0);

        // R9 interrupt
        bw(A_CTRL, cw(1, 8, 0, 4'h2));
        slave_reset(8);
        rep[0] = 32'h81;
        bw(A_CMD, 32'h1);
        bw(A_TXD, 32'h18);
        wait_frame(1);
        chk("R9 irq on not-empty", irq, 1);
        br(A_RXD, 1'b1, d);
        chk("R9 irq drops after read", irq, 0);
        bw(A_CTRL, cw(1, 8, 0, 4'h1));
        chk("R9 irq on not-full", irq, 1);
        bw(A_CTRL, cw(1, 8, 0, 4'h0));
        chk("R9 irq masked", irq, 0);

        // R11 divider: high phase lasts div+1 clocks
        bw(A_CTRL, cw(1, 4, 3, 4'h0));
        slave_reset(4);
        bw(A_CMD, 32'h1);
        bw(A_TXD, 32'h9);
        @(posedge sck_o);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sck_o === 1'b1 && n < 100);
        chk("R11 high phase clocks", n - 1, 4);
        wait_frame(1);
        br(A_RXD, 1'b1, d);

        // R10 conflicting master
        bw(A_CTRL, cw(1, 16, 7, 4'h8));
        slave_reset(16);
        bw(A_CMD, 32'h1);
        bw(A_TXD, 32'hBEEF);
        @(posedge sck_o);
        @(negedge clk);
        ssel_n_i = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 outputs released", {sck_oe, mosi_oe}, 0);
        chk("R10 select high", ss_n_o, 1);
        chk("R10 irq", irq, 1);
        br(A_EVT, 1'b0, d);
        chk("R10 error bit", d[3], 1);
        br(A_CTRL, 1'b0, d);
        chk("R10 master cleared", d[0], 0);
        ssel_n_i = 1'b1;
        bw(A_EVT, 32'h8);
        br(A_EVT, 1'b0, d);
        chk("R10 error w1c", d[3], 0);

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end

endmodule